// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Engine

This block is the identity layer of a slave on a single-wire bus. It runs at the level of bit events: a separate slot decoder gives it a strobe for each bit the master writes, a strobe for each read slot the master opens, and a strobe for each bus reset. The engine returns the level the slave drives during the current read slot. After a bus reset it takes in one eight-bit ROM command. It then reads out its 64-bit identity, compares the identity against a stream from the master, takes part in a search (plain or limited to devices whose alarm is set), or skips the identity exchange. At the end it either gives control to the function-command layer or stays silent until the next bus reset.

The identity is built from a family-code parameter, a 48-bit serial number input and a CRC-8 byte. The engine computes that byte itself with an unrolled shift-register chain.

States: `ST_IDLE` (silent until a bus reset; this is also the reset state and the drop-out state), `ST_CMD` (collecting the command byte), `ST_READ` (sending the identity), `ST_MATCH` (comparing the identity), `ST_S_TRUE` / `ST_S_CMP` / `ST_S_DIR` (the three slots of one search bit), `ST_FUNC` (the function layer owns the bus). Transitions:
- bus reset in any state goes to `ST_CMD`.
- `ST_CMD` goes on the eighth bit to `ST_READ`, `ST_MATCH`, `ST_S_TRUE`, `ST_FUNC` or `ST_IDLE`, depending on the code.
- `ST_READ` goes to `ST_FUNC` after 64 read slots.
- `ST_MATCH` goes to `ST_FUNC` when all 64 bits agree, and to `ST_IDLE` on the first difference.
- `ST_S_TRUE` goes to `ST_S_CMP` on a read slot.
- `ST_S_CMP` goes to `ST_S_DIR` on a read slot.
- `ST_S_DIR` goes to `ST_S_TRUE` when the master's bit agrees, and to `ST_IDLE` when it differs or after the last bit.

Top module: `rom_cmd_engine`

## Requirements
- R1: After the system reset `rst_n`, the engine is idle: `func_en_o` is 0, read slots return 1, and command bits are ignored until the first `bus_rst_i` strobe.
- R2: `tx_bit_o` is 1 in every cycle where `rd_req_i` is 0. It is also 1 during read slots in any state that does not transmit.
- R3: The command byte is the first eight `rx_valid_i` bits after a bus reset, least significant bit first. The codes are 33h read, 55h match, CCh skip, F0h search and ECh alarm search.
- R4: Identity bits 0..7 hold the `FAMILY` parameter and bits 8..55 hold `serial_i`. Bits 56..63 hold the CRC of bits 0..55 under x^8+x^5+x^4+1, fed LSB first into a register that starts at zero. Running all 64 identity bits through the same CRC leaves zero.
- R5: Read: the next 64 read slots return identity bits 0 to 63 in order. `func_en_o` is 1 in the cycle after the 64th slot.
- R6: Skip: `func_en_o` is 1 in the cycle after the eighth command bit.
- R7: Match: if 64 received bits equal the identity, `func_en_o` rises after the last bit. A single differing bit leaves `func_en_o` at 0 and makes later read slots return 1 until a bus reset.
- R8: Search: for each identity bit, in order, a read slot returns the bit and the next read slot returns its complement. The master's written bit then decides the outcome: a differing bit drops the slave out, so read slots return 1. After all 64 bits the engine is idle and `func_en_o` stays 0.
- R9: Alarm search behaves as search when `alarm_i` is 1 in the cycle of the eighth command bit. Otherwise the engine is idle and read slots return 1.
- R10: An unrecognised command code makes the engine idle: `func_en_o` 0, read slots 1, and later bits ignored.
- R11: `bus_rst_i` in any state returns the engine to command collection in the next cycle and drops `func_en_o`. It takes priority over a bit strobe in the same cycle, and that bit is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| serial_i | input | SER_W | Serial-number field of the identity |
| alarm_i | input | 1 | Alarm flag from the function layer |
| bus_rst_i | input | 1 | Bus reset/presence strobe |
| rx_valid_i | input | 1 | Strobe: master wrote a bit |
| rx_bit_i | input | 1 | Value of the written bit |
| rd_req_i | input | 1 | Strobe: master opened a read slot |
| tx_bit_o | output | 1 | Level to drive in the current read slot (1 = release) |
| func_en_o | output | 1 | Function-command layer owns the bus |

## Verification
`tx_bit_o` is due in the same cycle as `rd_req_i`, because it depends only on the state and not on any register after the strobe. The scoreboard monitor samples it a quarter period after the falling edge on which the driver raised the request. State changes, including `func_en_o`, settle at the rising edge that takes in a strobe. Each check of `func_en_o` is therefore made at the falling edge after that rising edge, one cycle after the strobe. Read data that the monitor collects is reused for the CRC residual check, so the CRC byte is checked as the design sent it.

// File: rtl/rom_eng_pkg.sv
package rom_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_S_TRUE,
        ST_S_CMP,
        ST_S_DIR,
        ST_FUNC
    } rom_state_e;

    localparam int CMD_W = 8;
    localparam int CRC_W = 8;

    localparam logic [CMD_W-1:0] CMD_READ    = 8'h33;
    localparam logic [CMD_W-1:0] CMD_MATCH   = 8'h55;
    localparam logic [CMD_W-1:0] CMD_SKIP    = 8'hCC;
    localparam logic [CMD_W-1:0] CMD_SEARCH  = 8'hF0;
    localparam logic [CMD_W-1:0] CMD_ASEARCH = 8'hEC;

endpackage

// File: rtl/rom_crc8.sv
module rom_crc8 #(
    parameter int DATA_W = 56
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [7:0]        crc_o
);

    logic [DATA_W:0][7:0] chain;

    assign chain[0] = 8'h00;

    for (genvar g = 0; g < DATA_W; g++) begin : g_stage
        logic fb;
        assign fb = chain[g][0] ^ data_i[g];
        assign chain[g+1] = {fb, chain[g][7:5], chain[g][4] ^ fb,
                             chain[g][3] ^ fb, chain[g][2:1]};
    end

    assign crc_o = chain[DATA_W];

endmodule

// File: rtl/rom_bit_index.sv
module rom_bit_index #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] idx_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_o <= '0;
        end else if (clr_i) begin
            idx_o <= '0;
        end else if (inc_i) begin
            idx_o <= idx_o + 1'b1;
        end
    end

endmodule

// File: rtl/rom_cmd_shift.sv
module rom_cmd_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] byte_next_o
);

    logic [W-1:0] sr_q;

    assign byte_next_o = {bit_i, sr_q[W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_i) begin
            sr_q <= byte_next_o;
        end
    end

endmodule

// File: rtl/rom_cmd_engine.sv
module rom_cmd_engine
    import rom_eng_pkg::*;
#(
    parameter int             FAM_W  = 8,
    parameter int             SER_W  = 48,
    parameter logic [FAM_W-1:0] FAMILY = 8'h3C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SER_W-1:0] serial_i,
    input  logic             alarm_i,
    input  logic             bus_rst_i,
    input  logic             rx_valid_i,
    input  logic             rx_bit_i,
    input  logic             rd_req_i,
    output logic             tx_bit_o,
    output logic             func_en_o
);

    localparam int BODY_W = FAM_W + SER_W;
    localparam int ID_W   = BODY_W + CRC_W;
    localparam int IDX_W  = $clog2(ID_W);
    localparam logic [IDX_W-1:0] ID_LAST  = IDX_W'(ID_W - 1);
    localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_W - 1);

    rom_state_e         state_q, state_d;
    logic [IDX_W-1:0]   idx;
    logic               cnt_clr, cnt_inc, cmd_shift;
    logic [CMD_W-1:0]   cmd_next;
    logic [CRC_W-1:0]   id_crc;
    logic [ID_W-1:0]    ident;
    logic               id_bit;

    rom_crc8 #(.DATA_W(BODY_W)) i_crc (
        .data_i ({serial_i, FAMILY}),
        .crc_o  (id_crc)
    );

    assign ident  = {id_crc, serial_i, FAMILY};
    assign id_bit = ident[idx];

    rom_bit_index #(.CNT_W(IDX_W)) i_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .idx_o (idx)
    );

    rom_cmd_shift #(.W(CMD_W)) i_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_i     (cmd_shift),
        .bit_i       (rx_bit_i),
        .byte_next_o (cmd_next)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and bit-index control
    always_comb begin
        state_d   = state_q;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        cmd_shift = 1'b0;
        if (bus_rst_i) begin
            state_d = ST_CMD;
            cnt_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_FUNC: ;
                ST_CMD: begin
                    if (rx_valid_i) begin
                        cmd_shift = 1'b1;
                        if (idx == CMD_LAST) begin
                            cnt_clr = 1'b1;
                            case (cmd_next)
                                CMD_READ:    state_d = ST_READ;
                                CMD_MATCH:   state_d = ST_MATCH;
                                CMD_SKIP:    state_d = ST_FUNC;
                                CMD_SEARCH:  state_d = ST_S_TRUE;
                                CMD_ASEARCH: state_d = alarm_i ? ST_S_TRUE : ST_IDLE;
                                default:     state_d = ST_IDLE;
                            endcase
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (rd_req_i) begin
                        if (idx == ID_LAST) begin
                            state_d = ST_FUNC;
                            cnt_clr = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                ST_MATCH: begin
                    if (rx_valid_i) begin
                        if (rx_bit_i != id_bit) begin
                            state_d = ST_IDLE;
                        end else if (idx == ID_LAST) begin
                            state_d = ST_FUNC;
                            cnt_clr = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                ST_S_TRUE: begin
                    if (rd_req_i) state_d = ST_S_CMP;
                end
                ST_S_CMP: begin
                    if (rd_req_i) state_d = ST_S_DIR;
                end
                ST_S_DIR: begin
                    if (rx_valid_i) begin
                        if (rx_bit_i != id_bit || idx == ID_LAST) begin
                            state_d = ST_IDLE;
                            cnt_clr = 1'b1;
                        end else begin
                            state_d = ST_S_TRUE;
                            cnt_inc = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        tx_bit_o  = 1'b1;
        func_en_o = (state_q == ST_FUNC);
        if (rd_req_i) begin
            unique case (state_q)
                ST_READ, ST_S_TRUE: tx_bit_o = id_bit;
                ST_S_CMP:           tx_bit_o = ~id_bit;
                default:            tx_bit_o = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/rom_eng_chk.sv
module rom_eng_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_rst_i,
    input logic rx_valid_i,
    input logic rd_req_i,
    input logic tx_bit_o,
    input logic func_en_o
);

    assert_release_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_i |-> tx_bit_o);

    assert_bus_reset_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_i |=> !func_en_o);

    assert_func_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (func_en_o && !bus_rst_i) |=> func_en_o);

    assert_func_after_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(func_en_o) |-> $past(rx_valid_i || rd_req_i));

    assert_func_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        func_en_o |-> tx_bit_o);

endmodule

bind rom_cmd_engine rom_eng_chk i_chk (.*);

// File: tb/test_rom_cmd_engine.sv
module test_rom_cmd_engine;

    localparam int CLK_P = 10;
    localparam logic [7:0]  FAM = 8'h3C;
    localparam logic [47:0] SER = 48'h9BCD_E712_345A;

    logic clk = 1'b0, rst_n = 1'b0, alarm = 1'b0, bus_rst = 1'b0;
    logic rx_valid = 1'b0, rx_bit = 1'b0, rd_req = 1'b0;
    logic [47:0] serial = SER;
    logic tx_bit, func_en;
    logic [63:0] ident;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct { logic b; int req; } exp_t;
    exp_t exp_q[$];
    logic seen_q[$];

    always #(CLK_P/2) clk = ~clk;

    rom_cmd_engine #(.FAMILY(FAM)) i_rom_cmd_engine (
        .clk(clk), .rst_n(rst_n), .serial_i(serial), .alarm_i(alarm),
        .bus_rst_i(bus_rst), .rx_valid_i(rx_valid), .rx_bit_i(rx_bit),
        .rd_req_i(rd_req), .tx_bit_o(tx_bit), .func_en_o(func_en)
    );

    function automatic logic [7:0] crc_bits(logic [63:0] d, int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            logic fb;
            fb = c[0] ^ d[i];
            c = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    task automatic check(logic act, logic exp, int req, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Monitor: compares each read slot against the scoreboard
    always @(negedge clk) begin
        #(CLK_P/4);
        if (rd_req) begin
            seen_q.push_back(tx_bit);
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected read slot: actual %b expected none", tx_bit);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (tx_bit !== e.b) begin
                    n_fail++;
                    $display("FAIL R%0d read slot: actual %b expected %b", e.req, tx_bit, e.b);
                end
            end
        end
    end

    task automatic put_bit(logic b);
        rx_valid = 1'b1; rx_bit = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic get_bit(logic exp, int req);
        exp_t e;
        e.b = exp; e.req = req;
        exp_q.push_back(e);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic bus_reset();
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
    endtask

    task automatic send_cmd(logic [7:0] c);
        for (int i = 0; i < 8; i++) put_bit(c[i]);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        ident = {crc_bits({8'h00, SER, FAM}, 56), SER, FAM};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, then commands ignored before a bus reset
        check(func_en, 1'b0, 1, "func_en after reset");
        #(CLK_P/4); check(tx_bit, 1'b1, 2, "tx released, no slot"); // R2
        @(negedge clk);
        send_cmd(8'hCC);
        check(func_en, 1'b0, 1, "skip ignored before bus reset");
        get_bit(1'b1, 1);

        // R6 / R3: skip
        bus_reset();
        send_cmd(8'hCC);
        check(func_en, 1'b1, 6, "skip enables function layer");
        get_bit(1'b1, 2); // R2: no transmit in function layer

        // R5: read identity, R4: CRC residual on what was sent
        bus_reset();
        check(func_en, 1'b0, 11, "bus reset drops func_en"); // R11
        send_cmd(8'h33);
        seen_q.delete();
        for (int i = 0; i < 64; i++) begin
            check(func_en, 1'b0, 5, "func_en low during read");
            get_bit(ident[i], 5);
        end
        check(func_en, 1'b1, 5, "func_en after 64 read slots");
        #(CLK_P/2);
        begin
            logic [63:0] rd;
            rd = '0;
            for (int i = 0; i < 64 && i < seen_q.size(); i++) rd[i] = seen_q[i];
            check(crc_bits(rd, 64) == 8'h00, 1'b1, 4, "CRC residual zero");
            check(rd[7:0] == FAM && rd[55:8] == SER, 1'b1, 4, "family/serial fields");
        end
        @(negedge clk);

        // R7: match, exact
        bus_reset();
        send_cmd(8'h55);
        for (int i = 0; i < 64; i++) put_bit(ident[i]);
        check(func_en, 1'b1, 7, "match exact");
        // R7: match with bit 10 flipped
        bus_reset();
        send_cmd(8'h55);
        for (int i = 0; i < 64; i++) put_bit((i == 10) ? ~ident[i] : ident[i]);
        check(func_en, 1'b0, 7, "match mismatch");
        get_bit(1'b1, 7);

        // R8: full search following own identity
        bus_reset();
        send_cmd(8'hF0);
        for (int i = 0; i < 64; i++) begin
            get_bit(ident[i], 8);
            get_bit(~ident[i], 8);
            put_bit(ident[i]);
        end
        check(func_en, 1'b0, 8, "no function layer after search");
        get_bit(1'b1, 8);

        // R8: drop out at bit 5
        bus_reset();
        send_cmd(8'hF0);
        for (int i = 0; i < 8; i++) begin
            if (i <= 5) begin
                get_bit(ident[i], 8);
                get_bit(~ident[i], 8);
                put_bit((i == 5) ? ~ident[i] : ident[i]);
            end else begin
                get_bit(1'b1, 8);
                get_bit(1'b1, 8);
                put_bit(ident[i]);
            end
        end
        check(func_en, 1'b0, 8, "dropped out of search");

        // R9: alarm search with alarm set, R11: bus reset mid-search
        alarm = 1'b1;
        bus_reset();
        send_cmd(8'hEC);
        for (int i = 0; i < 4; i++) begin
            get_bit(ident[i], 9);
            get_bit(~ident[i], 9);
            put_bit(ident[i]);
        end
        bus_reset();
        send_cmd(8'hCC);
        check(func_en, 1'b1, 11, "skip after reset mid-search");

        // R9: alarm search without alarm
        alarm = 1'b0;
        bus_reset();
        send_cmd(8'hEC);
        get_bit(1'b1, 9);
        get_bit(1'b1, 9);
        check(func_en, 1'b0, 9, "alarm search, no alarm");

        // R10: unrecognised command, later bits ignored
        bus_reset();
        send_cmd(8'hA5);
        check(func_en, 1'b0, 10, "unknown command");
        get_bit(1'b1, 10);
        send_cmd(8'hCC);
        check(func_en, 1'b0, 10, "bits ignored after unknown command");

        // R11: bus reset and bit strobe in the same cycle
        bus_rst = 1'b1; rx_valid = 1'b1; rx_bit = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0; rx_valid = 1'b0;
        send_cmd(8'hCC);
        check(func_en, 1'b1, 11, "coincident bit not counted");

        #(CLK_P/2);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 pending read slots: actual %0d expected 0", exp_q.size());
        end
        summary();
    end

endmodule